// File: doc/BRIEF.md
# External Interrupt Edge-Select Controller

This block collects interrupt requests for a small 8-bit microcontroller. Three external interrupt lines are watched, and the first two of them can each be taken from one of two alternate input ports. Two counter input pins are also watched, along with a one-clock timer Y underflow event. Every asynchronous pin passes through a two-flop synchronizer. An edge detector with a programmable active edge then looks at the result, and each detected edge sets a request flag. One request slot is shared: a select bit decides whether the timer Y event or the counter-1 edge feeds it.

Software reaches the block through a plain register port. The port holds the edge-select register, the counter-0 edge field, the counter-1 edge bit, the enable bits and the request flags. Each detector keeps its previous sample across a configuration change. Because of that, changing a polarity, a port route or the shared-slot source can raise a request on its own. Software hides such a request by disabling the source, changing the setting, clearing the flag one instruction later and then enabling the source again. The combined pending output is captured only in cycles that the CPU marks as instruction-acceptance points.

A request found in the last clock of an instruction lands at one of two sampling points. A parameter mask fixes which sources take the later point. This block has no streaming data, so it has no valid/ready interface, and every pin is plain control or status.

Top module: `irq_edge_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, every readable register reads 0 and `irq_pend_o` is 0.
- R2: External line n (n = 0, 1, 2) sets request bit n on the edge chosen by edge-select bit n (0 = rising, 1 = falling). The flag is readable after the third rising clock edge that follows the pin change. The opposite edge sets nothing.
- R3: Edge-select bit 4 routes external line 0, and bit 5 routes external line 1. A value of 0 takes port A and 1 takes port B. The port that is not selected has no effect.
- R4: Counter-0 input sets request bit 3 on the edge chosen by bits 7:6 of the timer X control register (address 1). The value 01 selects falling, 11 selects both edges, and 00 or 10 selects rising.
- R5: Request bit 4 is the shared slot. When edge-select bit 3 is 0, a timer Y pulse sets the bit on the next clock. When bit 3 is 1, a counter-1 edge sets it instead, with the edge chosen by bit 6 of the timer Y mode register (address 2, 0 = rising). The source that is not selected is ignored.
- R6: A configuration write can set a request flag one clock after it takes effect, with no pin activity. This happens when the write makes a detector's polarity-adjusted input rise, or when it toggles edge-select bit 3.
- R7: An event found in a cycle with `last_clk_i` high is set one clock late if its source bit is set in `LATE_MASK`. Every other source is set at the normal point.
- R8: Writing the request register (address 4) clears each flag whose data bit is 0, and a 1 has no effect. When a hardware set and a clear hit the same flag in the same cycle, the set wins.
- R9: `irq_pend_o` takes the OR of (request AND enable) at each clock where `accept_i` is high, and holds its value at all other clocks.
- R10: The read map is as follows. Address 0 is the edge-select byte. Address 1 reads only bits 7:6, and address 2 reads only bit 6. Addresses 3 and 4 read the enable and request bits in positions 4:0. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_a_i | input | 3 | Port A of external lines 0..2 |
| ext_b_i | input | 2 | Port B of external lines 0..1 |
| cnt_i | input | 2 | Counter-0 and counter-1 input pins |
| tmry_evt_i | input | 1 | Timer Y underflow pulse, synchronous |
| last_clk_i | input | 1 | Marks the last clock of an instruction |
| accept_i | input | 1 | Instruction-acceptance point |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_pend_o | output | 1 | Captured pending interrupt |

## Verification
Two functions can meet in one cycle. The first is a hardware set of a request flag. The second is a software write of 0 to that same flag, or the late landing of a deferred request next to a request that lands on time. The bench provokes the collision by raising a timer Y pulse in the same clock as a clearing write, and by lining up a synchronized pin edge with a timer pulse under `last_clk_i`. A behavioural model runs alongside the design and is compared on every clock. Directed checks then confirm which flag is readable at each of the two sampling points.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  localparam int NSRC = 5;
  localparam int N_EXT = 3;
  localparam int N_ALT = 2;
  localparam int N_PIN = N_EXT + N_ALT + 2;
  localparam int AW = 3;
  localparam int DW = 8;

  localparam int SRC_SHR = 4;
  localparam int SRC_CNT0 = 3;

  localparam int ES_SHARED = 3;
  localparam int ES_ROUTE0 = 4;

  typedef enum logic [AW-1:0] {
    A_ESEL = 3'd0,
    A_TXC  = 3'd1,
    A_TYM  = 3'd2,
    A_EN   = 3'd3,
    A_REQ  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic both_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign evt_o = both_i ? (lvl_i ^ prev_q) : (lvl_i & ~prev_q);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_edge_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] req_i,
  output logic [DW-1:0]   esel_o,
  output logic [1:0]      txf_o,
  output logic            typ_o,
  output logic [NSRC-1:0] en_o,
  output logic [DW-1:0]   rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esel_o <= '0;
      txf_o  <= '0;
      typ_o  <= 1'b0;
      en_o   <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_ESEL:  esel_o <= wdata_i;
        A_TXC:   txf_o  <= wdata_i[7:6];
        A_TYM:   typ_o  <= wdata_i[6];
        A_EN:    en_o   <= wdata_i[NSRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_ESEL:  rdata_o = esel_o;
      A_TXC:   rdata_o[7:6] = txf_o;
      A_TYM:   rdata_o[6] = typ_o;
      A_EN:    rdata_o[NSRC-1:0] = en_o;
      A_REQ:   rdata_o[NSRC-1:0] = req_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int          N = 5,
  parameter logic [N-1:0] LATE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         last_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] keep_i,
  input  logic [N-1:0] en_i,
  input  logic         accept_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] set_o,
  output logic [N-1:0] defer_o,
  output logic         pend_o
);
  logic [N-1:0] late, keep;

  assign late  = evt_i & {N{last_i}} & LATE_MASK;
  assign set_o = (evt_i & ~late) | defer_o;
  assign keep  = clr_we_i ? keep_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= '0;
      defer_o <= '0;
      pend_o  <= 1'b0;
    end else begin
      defer_o <= late;
      req_o   <= (req_o & keep) | set_o;
      if (accept_i) pend_o <= |(req_o & en_i);
    end
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_edge_pkg::*;
#(
  parameter logic [NSRC-1:0] LATE_MASK = 5'b10100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_a_i,
  input  logic [N_ALT-1:0] ext_b_i,
  input  logic [1:0]       cnt_i,
  input  logic             tmry_evt_i,
  input  logic             last_clk_i,
  input  logic             accept_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_pend_o
);
  logic [N_PIN-1:0] pin_s;
  logic [DW-1:0]    esel;
  logic [1:0]       txf;
  logic             typ;
  logic [NSRC-1:0]  en_vec, req_vec, set_vec, defer_vec, evt;
  logic             cnt1_evt, sel_prev;

  irq_sync #(.W(N_PIN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cnt_i, ext_b_i, ext_a_i}),
    .q_o(pin_s)
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    logic routed;
    if (g < N_ALT) begin : g_alt
      assign routed = esel[ES_ROUTE0+g] ? pin_s[N_EXT+g] : pin_s[g];
    end else begin : g_one
      assign routed = pin_s[g];
    end
    irq_edge_det u_det (
      .clk(clk), .rst_n(rst_n),
      .lvl_i(routed ^ esel[g]), .both_i(1'b0),
      .evt_o(evt[g])
    );
  end

  irq_edge_det u_cnt0 (
    .clk(clk), .rst_n(rst_n),
    .lvl_i(pin_s[N_EXT+N_ALT] ^ (txf == 2'b01)),
    .both_i(txf == 2'b11),
    .evt_o(evt[SRC_CNT0])
  );

  irq_edge_det u_cnt1 (
    .clk(clk), .rst_n(rst_n),
    .lvl_i(pin_s[N_EXT+N_ALT+1] ^ typ),
    .both_i(1'b0),
    .evt_o(cnt1_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= esel[ES_SHARED];
  end

  assign evt[SRC_SHR] = (esel[ES_SHARED] ? cnt1_evt : tmry_evt_i)
                      | (esel[ES_SHARED] ^ sel_prev);

  irq_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .req_i(req_vec),
    .esel_o(esel), .txf_o(txf), .typ_o(typ), .en_o(en_vec),
    .rdata_o(reg_rdata_o)
  );

  irq_req_bank #(.N(NSRC), .LATE_MASK(LATE_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .evt_i(evt), .last_i(last_clk_i),
    .clr_we_i(reg_we_i && reg_addr_i == A_REQ),
    .keep_i(reg_wdata_i[NSRC-1:0]),
    .en_i(en_vec), .accept_i(accept_i),
    .req_o(req_vec), .set_o(set_vec), .defer_o(defer_vec),
    .pend_o(irq_pend_o)
  );
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk
  import irq_edge_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            accept_i,
  input logic            irq_pend_o,
  input logic [NSRC-1:0] req_vec,
  input logic [NSRC-1:0] en_vec,
  input logic [NSRC-1:0] set_vec,
  input logic [NSRC-1:0] defer_vec
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (req_vec == '0 && !irq_pend_o));

  p_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_vec & ~$past(req_vec) & ~$past(set_vec)) == '0));

  p_hw_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~req_vec) == '0));

  p_late_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(defer_vec) & ~req_vec) == '0));

  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(irq_pend_o));

  p_pend_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (irq_pend_o == $past(|(req_vec & en_vec))));
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .irq_pend_o(irq_pend_o),
  .req_vec(req_vec), .en_vec(en_vec), .set_vec(set_vec), .defer_vec(defer_vec)
);

// File: tb/sim_irq_edge_ctrl.sv
module sim_irq_edge_ctrl;
  localparam int CLK_P = 10;
  localparam logic [4:0] LMASK = 5'b10100;

  logic clk = 0, rst_n = 0;
  logic [2:0] ext_a = 0;
  logic [1:0] ext_b = 0, cnt = 0;
  logic tmry = 0, last = 0, accept = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic pend;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit acc_hold = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_edge_ctrl #(.LATE_MASK(LMASK)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_a_i(ext_a), .ext_b_i(ext_b), .cnt_i(cnt),
    .tmry_evt_i(tmry), .last_clk_i(last), .accept_i(accept),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_pend_o(pend)
  );

  // behavioural reference
  logic [6:0] m_s1 = 0, m_s2 = 0;
  logic [4:0] m_prev = 0, m_en = 0, m_req = 0, m_def = 0;
  logic [7:0] m_esel = 0;
  logic [1:0] m_tx = 0;
  logic m_ty = 0, m_selp = 0, m_pend = 0;
  logic [4:0] lv, ev, lt, st, kp;
  logic c1ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_req = 0; m_def = 0;
      m_esel = 0; m_tx = 0; m_ty = 0; m_selp = 0; m_pend = 0;
    end else begin
      lv[0] = (m_esel[4] ? m_s2[3] : m_s2[0]) ^ m_esel[0];
      lv[1] = (m_esel[5] ? m_s2[4] : m_s2[1]) ^ m_esel[1];
      lv[2] = m_s2[2] ^ m_esel[2];
      lv[3] = m_s2[5] ^ (m_tx == 2'b01);
      lv[4] = m_s2[6] ^ m_ty;
      for (int k = 0; k < 3; k++) ev[k] = lv[k] && !m_prev[k];
      ev[3] = (m_tx == 2'b11) ? (lv[3] != m_prev[3]) : (lv[3] && !m_prev[3]);
      c1ev = lv[4] && !m_prev[4];
      ev[4] = (m_esel[3] ? c1ev : tmry) || (m_esel[3] != m_selp);
      lt = last ? (ev & LMASK) : 5'b0;
      st = (ev & ~lt) | m_def;
      kp = (we && addr == 3'd4) ? wdata[4:0] : 5'h1F;
      if (accept) m_pend = |(m_req & m_en);
      m_req = (m_req & kp) | st;
      m_def = lt;
      m_prev = lv;
      m_selp = m_esel[3];
      if (we) case (addr)
        3'd0: m_esel = wdata;
        3'd1: m_tx = wdata[7:6];
        3'd2: m_ty = wdata[6];
        3'd3: m_en = wdata[4:0];
        default: ;
      endcase
      m_s2 = m_s1;
      m_s1 = {cnt, ext_b, ext_a};
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_esel;
      3'd1: return {m_tx, 6'b0};
      3'd2: return {1'b0, m_ty, 6'b0};
      3'd3: return {3'b0, m_en};
      3'd4: return {3'b0, m_req};
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison, away from both clock edges
  always @(posedge clk) begin
    #(CLK_P/2 - 1);
    if (rst_n) begin
      n_chk++;
      if (rdata !== m_read(addr)) begin
        n_bad++;
        $display("FAIL R10 model compare addr %0d: actual %h expected %h", addr, rdata, m_read(addr));
      end
      n_chk++;
      if (pend !== m_pend) begin
        n_bad++;
        $display("FAIL R9 model compare pending: actual %b expected %b", pend, m_pend);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      accept = !acc_hold && (cyc % 3 == 0);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step(1);
    we = 0; addr = 3'd4; wdata = 0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin
      addr = 3'(a); #1;
      chk(rdata, 8'h00, "R1 reset register");
    end
    chk({7'b0, pend}, 8'h00, "R1 reset pending");
    addr = 3'd4;
    wr(3'd3, 8'h1F);

    // R2 rising edge latency on line 0
    ext_a[0] = 1; step(2);
    chk({7'b0, rdata[0]}, 8'h00, "R2 before third edge");
    step(1);
    chk({7'b0, rdata[0]}, 8'h01, "R2 rising sets flag");
    // R8 clear by zero, one ignored
    wr(3'd4, 8'h1E);
    chk(rdata, 8'h00, "R8 write zero clears");
    wr(3'd4, 8'hFF);
    chk(rdata, 8'h00, "R8 write one no effect");
    // R6 polarity change raises a flag
    wr(3'd0, 8'h02); step(1);
    chk({7'b0, rdata[1]}, 8'h01, "R6 polarity switch");
    wr(3'd4, 8'h00);
    // R2 falling polarity on line 1
    ext_a[1] = 1; step(4);
    chk({7'b0, rdata[1]}, 8'h00, "R2 rise ignored when falling");
    ext_a[1] = 0; step(3);
    chk({7'b0, rdata[1]}, 8'h01, "R2 falling sets flag");
    wr(3'd4, 8'h00);
    // R3 port routing
    ext_a[0] = 0; step(4);
    wr(3'd4, 8'h00);
    ext_b[0] = 1; step(4);
    chk(rdata, 8'h00, "R3 port B ignored while A routed");
    wr(3'd0, 8'h12); step(1);
    chk({7'b0, rdata[0]}, 8'h01, "R6 port switch");
    wr(3'd4, 8'h00);
    ext_b[0] = 0; step(3);
    ext_b[0] = 1; step(3);
    chk({7'b0, rdata[0]}, 8'h01, "R3 port B edge");
    wr(3'd4, 8'h00);
    ext_a[0] = 1; step(4);
    chk({7'b0, rdata[0]}, 8'h00, "R3 port A ignored while B routed");
    // R4 counter-0 edge field
    wr(3'd1, 8'hC0);
    cnt[0] = 1; step(3);
    chk({7'b0, rdata[3]}, 8'h01, "R4 both edges rise");
    wr(3'd4, 8'h00);
    cnt[0] = 0; step(3);
    chk({7'b0, rdata[3]}, 8'h01, "R4 both edges fall");
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h40); step(1);
    wr(3'd4, 8'h00);
    cnt[0] = 1; step(4);
    chk({7'b0, rdata[3]}, 8'h00, "R4 rise ignored when falling");
    cnt[0] = 0; step(3);
    chk({7'b0, rdata[3]}, 8'h01, "R4 falling sets flag");
    wr(3'd4, 8'h00);
    // R5 shared slot
    tmry = 1; step(1); tmry = 0;
    chk({7'b0, rdata[4]}, 8'h01, "R5 timer pulse");
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h1A); step(1);
    chk({7'b0, rdata[4]}, 8'h01, "R6 source switch");
    wr(3'd4, 8'h00);
    cnt[1] = 1; step(3);
    chk({7'b0, rdata[4]}, 8'h01, "R5 counter-1 edge");
    wr(3'd4, 8'h00);
    tmry = 1; step(1); tmry = 0; step(1);
    chk({7'b0, rdata[4]}, 8'h00, "R5 timer ignored when counter selected");
    // R7 two sampling points
    wr(3'd0, 8'h12); step(1);
    ext_b[0] = 0; step(3);
    wr(3'd4, 8'h00);
    ext_b[0] = 1; step(2);
    tmry = 1; last = 1; step(1); tmry = 0; last = 0;
    chk({7'b0, rdata[0]}, 8'h01, "R7 on-time source");
    chk({7'b0, rdata[4]}, 8'h00, "R7 late source not yet");
    step(1);
    chk({7'b0, rdata[4]}, 8'h01, "R7 late source lands");
    wr(3'd4, 8'h00);
    // R8 hardware set beats clear
    tmry = 1; we = 1; addr = 3'd4; wdata = 8'h00;
    step(1);
    tmry = 0; we = 0;
    chk({7'b0, rdata[4]}, 8'h01, "R8 set wins over clear");
    // R9 pending capture
    step(4);
    chk({7'b0, pend}, 8'h01, "R9 pending with enable");
    wr(3'd3, 8'h00); step(4);
    chk({7'b0, pend}, 8'h00, "R9 pending masked");
    acc_hold = 1; accept = 0;
    wr(3'd3, 8'h1F); step(3);
    chk({7'b0, pend}, 8'h00, "R9 held without accept");
    acc_hold = 0; step(4);
    chk({7'b0, pend}, 8'h01, "R9 captured at accept");
    // R10 read map
    wr(3'd1, 8'hFF); addr = 3'd1; #1;
    chk(rdata, 8'hC0, "R10 timer X field");
    wr(3'd2, 8'hFF); addr = 3'd2; #1;
    chk(rdata, 8'h40, "R10 timer Y bit");
    addr = 3'd3; #1;
    chk(rdata, 8'h1F, "R10 enable");
    addr = 3'd5; #1;
    chk(rdata, 8'h00, "R10 unused address");
    addr = 3'd4;
    step(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule